// File: doc/BRIEF.md
# Three-Channel Periodic Rate Timer

This block holds three identical 16-bit down-counting channels that all advance on one shared timer tick, supplied as a clock enable on the system clock. Each channel is set up through its own write strobe on a shared select and data bus. Software first writes a mode, then the low byte and then the high byte of the initial count.

In the rate mode a channel drops its output for one tick at the end of every count period, reloads itself and keeps going with no further writes. The gated mode would wait for a rising edge on a gate that is permanently tied high. That edge never arrives, so this mode serves as the way to stop a channel and keep its output high.

Top module: `tri_rate_timer`

## Requirements
- R1: After reset every output is high and no channel counts until it has been given a mode and a complete initial count.
- R2: The select encoding is: 0 writes the mode, with data bit 0 set to 1 for rate mode and 0 for gated mode; 1 writes the low count byte; 2 writes the high count byte; 3 has no effect on any channel.
- R3: A mode write forces the channel idle with its output high and discards any staged low byte. The channel stays idle until a low byte and then a high byte have been written.
- R4: In rate mode with initial count N, the output after the k-th tick that follows arming is low exactly when k is a multiple of N, and high otherwise. For N = 1 this means the output is low on every tick.
- R5: An initial count of 0 is treated as 65536.
- R6: Counting starts on the first tick after the cycle in which the high byte is written. A tick in the same cycle as a mode write or a high-byte write to that channel is not counted by that channel.
- R7: A channel in gated mode never counts, and its output stays high whatever counts are written.
- R8: A high byte written without a preceding low byte since the last mode write or arming is ignored, and counting continues undisturbed.
- R9: Channels are independent. In a cycle with no tick and no write to a channel, that channel's output holds its value.
- R10: Writing a complete new count while a channel runs in rate mode restarts the channel with the new count from the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Shared timer tick, one system clock wide |
| wr_en | input | 3 | Per-channel write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| tmr_out | output | 3 | Per-channel output, active-low pulse |

## Verification
A tick and a configuration write can arrive in the same cycle. The case that matters most is a high-byte or mode write that coincides with a tick, or that lands on the tick that would have produced a terminal pulse and a reload. The bench drives the write and the tick on the same clock edge. It then compares every output against a tick-count model in which the write wins and that tick is lost for the written channel only, while the other channels still count it.

// File: rtl/tri_rate_timer_pkg.sv
package tri_rate_timer_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CNT_LO = 2'd1,
    SEL_CNT_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    MODE_GATED = 1'b0,
    MODE_RATE  = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/rate_cnt.sv
module rate_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] reload_val,
  output logic          one_nxt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = reload_val;
    end else if (dec) begin
      if (cnt_q == ONE) cnt_d = reload_val;
      else              cnt_d = cnt_q - ONE;
    end
  end

  assign one_nxt = (cnt_d == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rate_chan.sv
module rate_chan
  import tri_rate_timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              out
);
  localparam int CW = 2 * BYTE_W;

  chan_mode_e        mode_q, mode_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              lo_ok_q, lo_ok_d;
  logic [CW-1:0]     rel_q, rel_d;
  logic              pend_q, pend_d;
  logic              run_q, run_d;
  logic              out_q, out_d;
  logic              cnt_load, cnt_dec, cnt_one_nxt;
  logic              wr_mode, wr_lo, wr_hi;

  assign wr_mode = wr && (sel == SEL_MODE);
  assign wr_lo   = wr && (sel == SEL_CNT_LO);
  assign wr_hi   = wr && (sel == SEL_CNT_HI) && lo_ok_q;

  always_comb begin
    mode_d   = mode_q;
    lo_d     = lo_q;
    lo_ok_d  = lo_ok_q;
    rel_d    = rel_q;
    pend_d   = pend_q;
    run_d    = run_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (wr_mode) begin
      mode_d  = chan_mode_e'(wdata[0]);
      lo_ok_d = 1'b0;
      pend_d  = 1'b0;
      run_d   = 1'b0;
    end else if (wr_hi) begin
      rel_d   = {wdata, lo_q};
      lo_ok_d = 1'b0;
      pend_d  = (mode_q == MODE_RATE);
      run_d   = 1'b0;
    end else begin
      if (wr_lo) begin
        lo_d    = wdata;
        lo_ok_d = 1'b1;
      end
      if (tick) begin
        if (pend_q) begin
          cnt_load = 1'b1;
          pend_d   = 1'b0;
          run_d    = 1'b1;
        end else if (run_q) begin
          cnt_dec = 1'b1;
        end
      end
    end
  end

  rate_cnt #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cnt_load),
    .dec        (cnt_dec),
    .reload_val (rel_q),
    .one_nxt    (cnt_one_nxt)
  );

  assign out_d = ~(run_d & cnt_one_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_GATED;
      lo_q    <= '0;
      lo_ok_q <= 1'b0;
      rel_q   <= '0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      lo_q    <= lo_d;
      lo_ok_q <= lo_ok_d;
      rel_q   <= rel_d;
      pend_q  <= pend_d;
      run_q   <= run_d;
      out_q   <= out_d;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/tri_rate_timer.sv
module tri_rate_timer
  import tri_rate_timer_pkg::*;
#(
  parameter int N_CH   = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [N_CH-1:0]   wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [N_CH-1:0]   tmr_out
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(wr_sel);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rate_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .wr    (wr_en[g]),
      .sel   (sel_e),
      .wdata (wr_data),
      .out   (tmr_out[g])
    );
  end
endmodule

// File: rtl/tri_rate_timer_chk.sv
module tri_rate_timer_chk #(
  parameter int N_CH   = 3,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [N_CH-1:0]   wr_en,
  input logic [1:0]        wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic [N_CH-1:0]   tmr_out
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    logic rate_seen_q;
    logic lo_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rate_seen_q <= 1'b0;
        lo_seen_q   <= 1'b0;
      end else if (wr_en[g]) begin
        if (wr_sel == 2'd0) begin
          rate_seen_q <= wr_data[0];
          lo_seen_q   <= 1'b0;
        end else if (wr_sel == 2'd1) begin
          lo_seen_q <= 1'b1;
        end else if (wr_sel == 2'd2) begin
          lo_seen_q <= 1'b0;
        end
      end
    end

    a_r3_mode_write_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[g] && wr_sel == 2'd0) |=> tmr_out[g]);

    a_r6_hi_write_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[g] && wr_sel == 2'd2 && lo_seen_q) |=> tmr_out[g]);

    a_r7_gated_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
      !rate_seen_q |-> tmr_out[g]);

    a_r9_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en[g]) |=> $stable(tmr_out[g]));
  end
endmodule

bind tri_rate_timer tri_rate_timer_chk #(.N_CH(N_CH), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tri_rate_timer_tb.sv
`timescale 1ns/1ps
module tri_rate_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic [2:0] wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [2:0] tmr_out;

  int checks;
  int failures;

  int   t_m   [3];
  int   n_m   [3];
  logic run_m [3];
  logic pend_m[3];
  logic rate_m[3];
  logic lok_m [3];
  logic [7:0] lo_m[3];

  tri_rate_timer u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .tmr_out (tmr_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic exp_out(int c);
    if (!run_m[c]) return 1'b1;
    return (t_m[c] % n_m[c]) != 0;
  endfunction

  task automatic check_all(input string tag);
    for (int c = 0; c < 3; c++) begin
      checks++;
      if (tmr_out[c] !== exp_out(c)) begin
        failures++;
        $display("FAIL %s ch%0d: out=%b expected=%b", tag, c, tmr_out[c], exp_out(c));
      end
    end
  endtask

  task automatic step(input logic tk, input logic [2:0] we, input logic [1:0] sel,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
    for (int c = 0; c < 3; c++) begin
      if (we[c] && sel == 2'd0) begin
        rate_m[c] = d[0]; lok_m[c] = 1'b0; pend_m[c] = 1'b0; run_m[c] = 1'b0;
      end else if (we[c] && sel == 2'd2 && lok_m[c]) begin
        n_m[c] = ({d, lo_m[c]} == 16'd0) ? 65536 : int'({d, lo_m[c]});
        lok_m[c] = 1'b0; pend_m[c] = rate_m[c]; run_m[c] = 1'b0;
      end else begin
        if (we[c] && sel == 2'd1) begin lo_m[c] = d; lok_m[c] = 1'b1; end
        if (tk) begin
          if (pend_m[c]) begin pend_m[c] = 1'b0; run_m[c] = 1'b1; t_m[c] = 1; end
          else if (run_m[c]) t_m[c]++;
        end
      end
    end
    @(posedge clk);
    #1;
    tick_en = 1'b0; wr_en = '0;
    check_all(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 3'b000, 2'd0, 8'h00, tag);
  endtask

  task automatic arm(input logic [2:0] we, input logic rate, input logic [15:0] n,
                     input string tag);
    step(1'b0, we, 2'd0, {7'd0, rate}, tag);
    step(1'b0, we, 2'd1, n[7:0], tag);
    step(1'b0, we, 2'd2, n[15:8], tag);
  endtask

  task automatic t_reset();
    checks++;
    if (tmr_out !== 3'b111) begin
      failures++;
      $display("FAIL R1 reset: out=%b expected=111", tmr_out);
    end
    ticks(6, "R1");
  endtask

  task automatic t_rate_basic();
    arm(3'b001, 1'b1, 16'd3, "R4");
    arm(3'b010, 1'b1, 16'd5, "R4");
    ticks(12, "R4");
    for (int i = 0; i < 14; i++) step(i % 3 != 1, 3'b000, 2'd0, 8'h00, "R9");
  endtask

  task automatic t_start_tie();
    step(1'b0, 3'b100, 2'd0, 8'h01, "R6");
    step(1'b1, 3'b100, 2'd1, 8'h04, "R6");
    step(1'b1, 3'b100, 2'd2, 8'h00, "R6");
    ticks(9, "R6");
    step(1'b1, 3'b001, 2'd0, 8'h01, "R6");
    ticks(3, "R6");
  endtask

  task automatic t_gated();
    arm(3'b100, 1'b0, 16'd2, "R7");
    ticks(8, "R7");
    arm(3'b100, 1'b0, 16'd1, "R7");
    ticks(4, "R7");
  endtask

  task automatic t_sel_none();
    step(1'b1, 3'b111, 2'd3, 8'hFF, "R2");
    ticks(5, "R2");
  endtask

  task automatic t_hi_only();
    arm(3'b001, 1'b1, 16'd4, "R8");
    ticks(2, "R8");
    step(1'b1, 3'b001, 2'd2, 8'h00, "R8");
    ticks(6, "R8");
  endtask

  task automatic t_mode_mid();
    arm(3'b010, 1'b1, 16'd3, "R3");
    ticks(2, "R3");
    step(1'b0, 3'b010, 2'd1, 8'h02, "R3");
    step(1'b1, 3'b010, 2'd0, 8'h01, "R3");
    step(1'b0, 3'b010, 2'd2, 8'h00, "R3");
    ticks(5, "R3");
    step(1'b1, 3'b010, 2'd1, 8'h02, "R3");
    ticks(3, "R3");
    step(1'b0, 3'b010, 2'd2, 8'h00, "R3");
    ticks(6, "R3");
  endtask

  task automatic t_rewrite();
    arm(3'b001, 1'b1, 16'd5, "R10");
    ticks(3, "R10");
    step(1'b1, 3'b001, 2'd1, 8'h02, "R10");
    step(1'b1, 3'b001, 2'd2, 8'h00, "R10");
    ticks(7, "R10");
  endtask

  task automatic t_one();
    arm(3'b100, 1'b1, 16'd1, "R4");
    ticks(5, "R4");
    step(1'b0, 3'b000, 2'd0, 8'h00, "R4");
  endtask

  task automatic t_zero();
    arm(3'b010, 1'b1, 16'd0, "R5");
    ticks(65540, "R5");
  endtask

  initial begin
    #1_900_000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    tick_en = 1'b0; wr_en = '0; wr_sel = '0; wr_data = '0;
    for (int c = 0; c < 3; c++) begin
      t_m[c] = 0; n_m[c] = 1; run_m[c] = 1'b0; pend_m[c] = 1'b0;
      rate_m[c] = 1'b0; lok_m[c] = 1'b0; lo_m[c] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_rate_basic();
    t_start_tie();
    t_gated();
    t_sel_none();
    t_hi_only();
    t_mode_mid();
    t_rewrite();
    t_one();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule